// File: doc/BRIEF.md
# Set/Clear Addressable Status Register Bank

This block is the register file that sits behind a transceiver's register access port. Every writable control byte is reachable through three neighbouring addresses. A write to the first address loads the byte. A write to the second address ORs the written ones into it. A write to the third address clears the bits that are written as ones. Software can therefore change single bits without a read-modify-write sequence.

Next to the control bytes there are four fixed identity bytes and a scratch byte. There is also an interrupt section. That section holds:
- a live view of five bus-status signals,
- rising-edge and falling-edge enable masks,
- a sticky event register that records every unmasked edge.

Reading the event register clears it. The pending flag is the OR of all recorded events, and the surrounding logic uses it to request a receive-command byte. The command decoding that produces the read and write strobes sits outside this block.

Top module: `sab_regbank`

## Requirements
- R1: After reset the rising and falling enable masks read 1Fh, the control byte and scratch byte read 00h, the event register reads 00h and `irq_pend` is 0.
- R2: Addresses 00h..03h return the fixed identity bytes CCh, 04h, 07h and 15h. Writes to these addresses leave them unchanged.
- R3: For the control byte (04h/05h/06h), the scratch byte (16h/17h/18h), the rising mask (0Dh/0Eh/0Fh) and the falling mask (10h/11h/12h), a write to base loads the value, base+1 sets the written ones and base+2 clears them. The masks keep only bits 4:0, and their bits 7:5 read 0.
- R4: Address 13h returns the status inputs after a two-flop synchronizer, so a change shows in a read two clocks later. Bit 0 is host-disconnect, bit 1 is VBUS-valid, bit 2 is session-valid, bit 3 is session-end and bit 4 is ID-ground. Bits 7:5 read 0.
- R5: A 0-to-1 change of a synchronized status bit sets the matching bit of the event register (address 14h) only when that bit of the rising mask is 1.
- R6: A 1-to-0 change of a synchronized status bit sets the matching event bit only when that bit of the falling mask is 1.
- R7: A read of 14h returns the event register and then clears it. An event that is recorded in the same cycle as the read stays set.
- R8: `irq_pend` is 1 exactly when some event bit is set.
- R9: Reads of unused addresses (07h..0Ch, 15h, 19h..3Fh) return 00h. Writes to them change no register.
- R10: `rd_data` changes only in the cycle after `reg_rd` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| sts_in | input | 5 | Raw status signals, bit layout as in R4 |
| rd_data | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq_pend | output | 1 | At least one event is recorded |

## Verification
The properties assume the following about the inputs:
- `reg_rd` is only high for one address at a time.
- Status inputs may change at any time, because they are asynchronous and enter through the synchronizer.
- A read of the event register is the only way to clear it.

The stimulus drives all strobes and status values on the falling clock edge. It changes the status inputs only while the edge it intends to test is enabled or deliberately masked. For the read-collision case, it places one status change exactly two cycles before a read, so that the new event and the clear meet in the same edge.

// File: rtl/sab_pkg.sv
// Shared constants for the set/clear register bank: widths, register
// addresses and the status bit layout. Assumes 6-bit register addressing.
package sab_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int STS_W  = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t A_ID0   = 6'h00;
    localparam addr_t A_ID1   = 6'h01;
    localparam addr_t A_ID2   = 6'h02;
    localparam addr_t A_ID3   = 6'h03;
    localparam addr_t A_CTRL  = 6'h04;
    localparam addr_t A_RISE  = 6'h0D;
    localparam addr_t A_FALL  = 6'h10;
    localparam addr_t A_STS   = 6'h13;
    localparam addr_t A_LATCH = 6'h14;
    localparam addr_t A_SCR   = 6'h16;

    localparam int B_HOSTDIS = 0;
    localparam int B_VBUSVLD = 1;
    localparam int B_SESSVLD = 2;
    localparam int B_SESSEND = 3;
    localparam int B_IDGND   = 4;
endpackage

// File: rtl/sab_alias_reg.sv
// One control register seen at three addresses: BASE loads, BASE+1 sets
// the written ones, BASE+2 clears them. Assumes at most one write per cycle.
module sab_alias_reg
    import sab_pkg::*;
#(
    parameter int     W    = 8,
    parameter addr_t  BASE = 6'h00,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  addr_t        addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    localparam addr_t A_SET = BASE + addr_t'(1);
    localparam addr_t A_CLR = BASE + addr_t'(2);

    // Register update: load, set or clear depending on the alias hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (wr_en) begin
            if (addr == BASE)       q <= wdata;
            else if (addr == A_SET) q <= q | wdata;
            else if (addr == A_CLR) q <= q & ~wdata;
        end
    end
endmodule

// File: rtl/sab_sync_edge.sv
// Two-flop synchronizer for asynchronous status inputs followed by a
// one-cycle history flop that yields per-bit rise and fall pulses.
// Assumes inputs are quasi-static levels; after reset all history is 0.
module sab_sync_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Synchronizer chain plus previous-cycle copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses compare the synchronized value with last cycle's.
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end
endmodule

// File: rtl/sab_irq_latch.sv
// Sticky event register. Each bit records an enabled rise or fall of its
// status signal and is cleared by a read strobe. A new event in the clear
// cycle wins over the clear.
module sab_irq_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] en_rise,
    input  logic [W-1:0] en_fall,
    input  logic         rd_clr,
    output logic [W-1:0] latch,
    output logic         pend
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hit;
        // Unmasked edge detection for this bit.
        always_comb hit = (rise[i] & en_rise[i]) | (fall[i] & en_fall[i]);

        // Sticky bit: set by an event, cleared by a read, the event wins.
        always_ff @(posedge clk) begin
            if (!rst_n)      latch[i] <= 1'b0;
            else if (hit)    latch[i] <= 1'b1;
            else if (rd_clr) latch[i] <= 1'b0;
        end
    end

    // Pending flag is the OR of all recorded events.
    always_comb pend = |latch;
endmodule

// File: rtl/sab_regbank.sv
// Top of the set/clear register bank. Holds identity bytes, a control byte,
// a scratch byte, edge enable masks, live status and the sticky event
// register. Read data is registered; unused addresses read 00h.
// Assumes reg_wr and reg_rd come from an external command decoder.
module sab_regbank
    import sab_pkg::*;
#(
    parameter byte_t ID0 = 8'hCC,
    parameter byte_t ID1 = 8'h04,
    parameter byte_t ID2 = 8'h07,
    parameter byte_t ID3 = 8'h15,
    parameter logic [STS_W-1:0] EN_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [STS_W-1:0]  sts_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pend
);
    localparam int PAD_W = DATA_W - STS_W;

    byte_t              ctrl_q;
    byte_t              scr_q;
    logic [STS_W-1:0]   en_rise;
    logic [STS_W-1:0]   en_fall;
    logic [STS_W-1:0]   sts_lvl;
    logic [STS_W-1:0]   sts_rise;
    logic [STS_W-1:0]   sts_fall;
    logic [STS_W-1:0]   evt_q;
    logic               evt_rd;
    byte_t              rd_mux;

    sab_alias_reg #(.W(DATA_W), .BASE(A_CTRL), .RST('0)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .q(ctrl_q));

    sab_alias_reg #(.W(DATA_W), .BASE(A_SCR), .RST('0)) u_scr (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .q(scr_q));

    sab_alias_reg #(.W(STS_W), .BASE(A_RISE), .RST(EN_RST)) u_en_rise (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata[STS_W-1:0]), .q(en_rise));

    sab_alias_reg #(.W(STS_W), .BASE(A_FALL), .RST(EN_RST)) u_en_fall (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata[STS_W-1:0]), .q(en_fall));

    sab_sync_edge #(.W(STS_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(sts_in),
        .level(sts_lvl), .rise(sts_rise), .fall(sts_fall));

    // Clear-on-read strobe for the event register.
    always_comb evt_rd = reg_rd && (reg_addr == A_LATCH);

    sab_irq_latch #(.W(STS_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .rise(sts_rise), .fall(sts_fall),
        .en_rise(en_rise), .en_fall(en_fall), .rd_clr(evt_rd),
        .latch(evt_q), .pend(irq_pend));

    // Read multiplexer: every alias of a register returns its value.
    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            A_ID0:                        rd_mux = ID0;
            A_ID1:                        rd_mux = ID1;
            A_ID2:                        rd_mux = ID2;
            A_ID3:                        rd_mux = ID3;
            6'h04, 6'h05, 6'h06:          rd_mux = ctrl_q;
            6'h0D, 6'h0E, 6'h0F:          rd_mux = {{PAD_W{1'b0}}, en_rise};
            6'h10, 6'h11, 6'h12:          rd_mux = {{PAD_W{1'b0}}, en_fall};
            A_STS:                        rd_mux = {{PAD_W{1'b0}}, sts_lvl};
            A_LATCH:                      rd_mux = {{PAD_W{1'b0}}, evt_q};
            6'h16, 6'h17, 6'h18:          rd_mux = scr_q;
            default:                      rd_mux = '0;
        endcase
    end

    // Registered read port, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (reg_rd) rd_data <= rd_mux;
    end
endmodule

// File: rtl/sab_regbank_chk.sv
// Port-level properties of the register bank, attached by bind.
module sab_regbank_chk
    import sab_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_pend
);
    AST_ID_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == A_ID3 |=> rd_data == 8'h15); // R2

    AST_STS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == A_STS |=> rd_data[7:5] == 3'b000); // R4

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend && !(reg_rd && reg_addr == A_LATCH) |=> irq_pend); // R7

    AST_IDLE_LATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == A_LATCH && !irq_pend |=> rd_data == 8'h00); // R8

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr >= 6'h19 |=> rd_data == 8'h00); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(rd_data)); // R10
endmodule

bind sab_regbank sab_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .rd_data(rd_data), .irq_pend(irq_pend));

// File: tb/sab_regbank_tb_top.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor pops them
// when rd_data becomes valid and compares.
module sab_regbank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [4:0] sts_in = '0;
    logic [7:0] rd_data;
    logic       irq_pend;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sab_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sts_in(sts_in),
        .rd_data(rd_data), .irq_pend(irq_pend));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(req);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare rd_data one cycle after each read strobe.
    initial begin
        forever begin
            @(posedge clk);
            if (reg_rd && rst_n) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected read", rd_data, 8'h00);
                end else begin
                    chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_pend", {7'b0, irq_pend}, 8'h00);
        rd(6'h0D, 8'h1F, "R1 rise mask");
        rd(6'h10, 8'h1F, "R1 fall mask");
        rd(6'h04, 8'h00, "R1 ctrl");
        rd(6'h16, 8'h00, "R1 scratch");
        rd(6'h14, 8'h00, "R1 events");

        // R2 identity bytes
        rd(6'h00, 8'hCC, "R2 id0");
        rd(6'h01, 8'h04, "R2 id1");
        rd(6'h02, 8'h07, "R2 id2");
        rd(6'h03, 8'h15, "R2 id3");
        wr(6'h03, 8'hAA);
        rd(6'h03, 8'h15, "R2 id3 after write");

        // R3 load / set / clear aliases
        wr(6'h04, 8'h5A); rd(6'h04, 8'h5A, "R3 ctrl load");
        wr(6'h05, 8'h81); rd(6'h05, 8'hDB, "R3 ctrl set");
        wr(6'h06, 8'h0A); rd(6'h06, 8'hD1, "R3 ctrl clear");
        wr(6'h16, 8'hF0); wr(6'h17, 8'h0F); rd(6'h16, 8'hFF, "R3 scratch set");
        wr(6'h18, 8'h3C); rd(6'h18, 8'hC3, "R3 scratch clear");
        wr(6'h0D, 8'hE5); rd(6'h0D, 8'h05, "R3 rise mask width");
        wr(6'h0F, 8'h1E); rd(6'h0D, 8'h01, "R3 rise mask clear");
        wr(6'h0E, 8'h04); rd(6'h0E, 8'h05, "R3 rise mask set");
        wr(6'h10, 8'h02); rd(6'h12, 8'h02, "R3 fall mask load");

        // R4 status view; R5 masked rises record nothing
        @(negedge clk) sts_in = 5'b01010;
        idle(4);
        rd(6'h13, 8'h0A, "R4 status");
        chk("R5 masked rise irq", {7'b0, irq_pend}, 8'h00);
        rd(6'h14, 8'h00, "R5 masked rise events");

        // R5 enabled rise
        @(negedge clk) sts_in = 5'b01011;
        idle(4);
        chk("R8 pend after rise", {7'b0, irq_pend}, 8'h01);
        rd(6'h14, 8'h01, "R5 rise event");
        chk("R8 pend after clear", {7'b0, irq_pend}, 8'h00);
        rd(6'h14, 8'h00, "R7 cleared by read");

        // R6 enabled fall
        @(negedge clk) sts_in = 5'b01001;
        idle(4);
        rd(6'h13, 8'h09, "R4 status after fall");
        rd(6'h14, 8'h02, "R6 fall event");

        // R7 event meets the clearing read in the same edge
        @(negedge clk) sts_in = 5'b01101;
        @(negedge clk);
        rd(6'h14, 8'h00, "R7 read during event");
        chk("R7 pend survives", {7'b0, irq_pend}, 8'h01);
        rd(6'h14, 8'h04, "R7 event kept");
        chk("R8 pend low", {7'b0, irq_pend}, 8'h00);

        // R5 masked rise of bit 4
        @(negedge clk) sts_in = 5'b11101;
        idle(4);
        rd(6'h14, 8'h00, "R5 masked id rise");
        rd(6'h13, 8'h1D, "R4 status id ground");

        // R9 unused addresses
        rd(6'h1A, 8'h00, "R9 unused 1A");
        rd(6'h3F, 8'h00, "R9 unused 3F");
        rd(6'h08, 8'h00, "R9 unused 08");
        wr(6'h1A, 8'hFF); wr(6'h08, 8'hFF); wr(6'h15, 8'hFF);
        rd(6'h04, 8'hD1, "R9 ctrl untouched");
        rd(6'h16, 8'hC3, "R9 scratch untouched");
        rd(6'h15, 8'h00, "R9 unused 15");

        // R10 read data holds without a strobe
        rd(6'h03, 8'h15, "R10 setup");
        idle(5);
        chk("R10 hold", rd_data, 8'h15);

        idle(2);
        if (exp_q.size() != 0) chk("R10 pending reads", 8'(exp_q.size()), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule